// File: doc/BRIEF.md
# I2C Master SCL Phase Generator

This block produces the clock-line waveform and the bus-condition timing for an I2C master. It counts core clock cycles against programmable high and low counts, kept as one pair for standard mode and one pair for fast mode and chosen by a speed-mode input. From these counts it times the hold of SDA after a START, the low and high phases of each bit, the setup of a STOP and the high time seen before a repeated START. Its outputs are the open-drain pull enables for SCL and SDA (1 means pull the line low).

A byte engine drives it one bus event at a time through a valid/ready request port: a START, a STOP or a single bit. For a bit it hands over the SDA value to place on the line. At the end of each SCL high phase the block pulses a bit-done strobe and reports the sampled SDA level, which carries received data or the slave's ACK. A separate detector reports when both bus lines have stayed high long enough to call the bus free. Clock stretching and spike filtering are not handled.

Top module: `scl_timing_gen`

## Requirements
- R1: Four CNT_W-bit count registers are selected by `cfg_sel_i`: 0 standard high, 1 standard low, 2 fast high, 3 fast low. After reset they hold 427, 499, 87 and 159 (for a 100 MHz core clock). `fast_i`=1 uses the fast pair and 0 the standard pair; below, H and L mean the selected high and low counts.
- R2: A write (`cfg_we_i`=1) is ignored while `en_i` is 1 and takes effect while `en_i` is 0.
- R3: A START accepted while the bus is free drives SDA low at the acceptance edge. SCL is pulled low H+3 cycles later.
- R4: An SCL low phase is counted from the edge that pulls SCL low and lasts at least L+1 cycles. It is extended until a request is pending. The SDA value of a request taken during the low phase is applied at its acceptance edge.
- R5: The SCL high phase of a bit lasts H+8 cycles. SCL is then pulled low again.
- R6: `bit_done_o` is a one-cycle pulse raised on the edge that ends a bit's high phase, together with the SCL pull. `rx_bit_o` holds SDA as sampled at that edge.
- R7: A STOP drives SDA low from its acceptance through the rest of the low phase. SCL is then released, and SDA is released H+1 cycles later, which leaves the bus free.
- R8: A START taken while SCL is low (a repeated START) releases SDA at acceptance. It then releases SCL for H+8 cycles and drives SDA low, after which the timing of R3 applies.
- R9: Request ops are 0 = bit, 1 = START, 2 = STOP, and 3 acts as a bit. `req_ready_o` is 1 when enabled and either the bus is free or SCL is low with no request pending. A bit or STOP accepted while the bus is free has no effect on the lines.
- R10: With `en_i`=0 both line drives are released on the next edge, `req_ready_o` is 0, and the block returns to the bus-free state.
- R11: `bus_idle_o` is 1 once SCL and SDA have been sampled high on H+1 consecutive edges. It drops after the first edge that samples either line low.
- R12: While enabled, the SCL and SDA drives never change on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Controller enable; locks the count registers |
| fast_i | input | 1 | 1 selects the fast-mode count pair |
| cfg_we_i | input | 1 | Count register write strobe |
| cfg_sel_i | input | 2 | Count register index |
| cfg_data_i | input | CNT_W | Count register write data |
| req_valid_i | input | 1 | Bus event request valid |
| req_op_i | input | 2 | Event kind: bit, START, STOP |
| req_bit_i | input | 1 | SDA value for a bit request |
| req_ready_o | output | 1 | Request accepted on this edge when valid |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_oe_o | output | 1 | Pull SDA low |
| bit_done_o | output | 1 | End of a bit's high phase |
| rx_bit_o | output | 1 | SDA sampled at end of the high phase |
| bus_idle_o | output | 1 | Both lines have been high long enough |

## Verification
The bench measures the length of every segment of the two drive outputs with a cycle counter. An off-by-one in the START hold, low phase, high phase or STOP setup therefore shows up directly as a wrong segment length, and a drive that moves out of order shows up as a wrong pair of levels. A repeated START right after a bit that a slave acknowledged is covered. A design that left SDA driven would produce a segment the bench does not expect, and one that sampled SDA at the wrong edge would report the ACK as 1. Other cases covered: a count write made while enabled, which must leave the fast timing unchanged; bit and STOP requests given while the bus is free, which must not move either line; a disable in the middle of a START hold, which must free both lines at once; and the bus-free detector at exactly H and H+1 high edges.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  localparam logic [1:0] OP_BIT   = 2'd0;
  localparam logic [1:0] OP_START = 2'd1;
  localparam logic [1:0] OP_STOP  = 2'd2;

  typedef enum logic [2:0] {
    ST_FREE, ST_HOLD, ST_LOW, ST_HIGH, ST_RS_HIGH, ST_STOP_HIGH
  } phase_e;

  typedef enum logic [1:0] {PEND_BIT, PEND_START, PEND_STOP} pend_e;
endpackage

// File: rtl/scl_cnt_regs.sv
module scl_cnt_regs #(
  parameter int CNT_W = 16,
  parameter int SS_H  = 427,
  parameter int SS_L  = 499,
  parameter int FS_H  = 87,
  parameter int FS_L  = 159
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lock_i,
  input  logic             we_i,
  input  logic [1:0]       sel_i,
  input  logic [CNT_W-1:0] data_i,
  input  logic             fast_i,
  output logic [CNT_W-1:0] hcnt_o,
  output logic [CNT_W-1:0] lcnt_o
);
  localparam int NREG = 4;

  function automatic logic [CNT_W-1:0] rst_val(input int idx);
    case (idx)
      0:       return CNT_W'(SS_H);
      1:       return CNT_W'(SS_L);
      2:       return CNT_W'(FS_H);
      default: return CNT_W'(FS_L);
    endcase
  endfunction

  logic [CNT_W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  regs_q[g] <= rst_val(g);
      else if (we_i && !lock_i && sel_i == 2'(g))   regs_q[g] <= data_i;
    end

    assert_lock_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_i |=> $stable(regs_q[g]));
  end

  assign hcnt_o = fast_i ? regs_q[2] : regs_q[0];
  assign lcnt_o = fast_i ? regs_q[3] : regs_q[1];
endmodule

// File: rtl/scl_idle_det.sv
module scl_idle_det #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [CNT_W-1:0] hcnt_i,
  output logic             idle_o
);
  localparam int IW = CNT_W + 1;

  logic [IW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                run_q <= '0;
    else if (!(scl_i && sda_i)) run_q <= '0;
    else if (run_q != '1)       run_q <= run_q + 1'b1;
  end

  assign idle_o = run_q > {1'b0, hcnt_i};

  assert_idle_lines_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> $past(scl_i && sda_i));
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] hcnt_i,
  input  logic [CNT_W-1:0] lcnt_i,
  input  logic             req_valid_i,
  input  logic [1:0]       req_op_i,
  input  logic             req_bit_i,
  output logic             req_ready_o,
  input  logic             sda_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             bit_done_o,
  output logic             rx_bit_o
);
  localparam int TW = CNT_W + 1;

  phase_e        st_q;
  pend_e         pend_op_q;
  logic          pend_q;
  logic [TW-1:0] cnt_q;
  logic          scl_oe_q, sda_oe_q, done_q, rx_q;

  logic [TW-1:0] hold_lim, high_lim, stop_lim, low_lim;
  logic          accept;

  assign hold_lim = {1'b0, hcnt_i} + TW'(2);
  assign high_lim = {1'b0, hcnt_i} + TW'(7);
  assign stop_lim = {1'b0, hcnt_i};
  assign low_lim  = {1'b0, lcnt_i};

  assign req_ready_o = en_i && (st_q == ST_FREE || (st_q == ST_LOW && !pend_q));
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_FREE; pend_q <= 1'b0; pend_op_q <= PEND_BIT; cnt_q <= '0;
      scl_oe_q <= 1'b0; sda_oe_q <= 1'b0; done_q <= 1'b0; rx_q <= 1'b1;
    end else if (!en_i) begin
      st_q <= ST_FREE; pend_q <= 1'b0; cnt_q <= '0;
      scl_oe_q <= 1'b0; sda_oe_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_FREE: if (accept && req_op_i == OP_START) begin
          sda_oe_q <= 1'b1; cnt_q <= '0; st_q <= ST_HOLD;
        end
        ST_HOLD: if (cnt_q >= hold_lim) begin
          scl_oe_q <= 1'b1; cnt_q <= '0; st_q <= ST_LOW;
        end else cnt_q <= cnt_q + 1'b1;
        ST_LOW: begin
          if (accept) begin
            pend_q <= 1'b1;
            case (req_op_i)
              OP_START: begin pend_op_q <= PEND_START; sda_oe_q <= 1'b0; end
              OP_STOP:  begin pend_op_q <= PEND_STOP;  sda_oe_q <= 1'b1; end
              default:  begin pend_op_q <= PEND_BIT;   sda_oe_q <= ~req_bit_i; end
            endcase
          end
          if (cnt_q >= low_lim) begin
            if (pend_q) begin
              scl_oe_q <= 1'b0; cnt_q <= '0; pend_q <= 1'b0;
              case (pend_op_q)
                PEND_START: st_q <= ST_RS_HIGH;
                PEND_STOP:  st_q <= ST_STOP_HIGH;
                default:    st_q <= ST_HIGH;
              endcase
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_HIGH: if (cnt_q >= high_lim) begin
          scl_oe_q <= 1'b1; done_q <= 1'b1; rx_q <= sda_i; cnt_q <= '0; st_q <= ST_LOW;
        end else cnt_q <= cnt_q + 1'b1;
        ST_RS_HIGH: if (cnt_q >= high_lim) begin
          sda_oe_q <= 1'b1; cnt_q <= '0; st_q <= ST_HOLD;
        end else cnt_q <= cnt_q + 1'b1;
        ST_STOP_HIGH: if (cnt_q >= stop_lim) begin
          sda_oe_q <= 1'b0; cnt_q <= '0; st_q <= ST_FREE;
        end else cnt_q <= cnt_q + 1'b1;
        default: st_q <= ST_FREE;
      endcase
    end
  end

  assign scl_oe_o   = scl_oe_q;
  assign sda_oe_o   = sda_oe_q;
  assign bit_done_o = done_q;
  assign rx_bit_o   = rx_q;

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_done_o |=> !bit_done_o);
  assert_done_with_pull_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_done_o |-> (scl_oe_o && !$past(scl_oe_o)));
  assert_no_joint_edge_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i)) |-> !($changed(scl_oe_o) && $changed(sda_oe_o)));
  assert_off_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!scl_oe_o && !sda_oe_o));
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
  parameter int CNT_W    = 16,
  parameter int CORE_KHZ = 100000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             fast_i,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_sel_i,
  input  logic [CNT_W-1:0] cfg_data_i,
  input  logic             req_valid_i,
  input  logic [1:0]       req_op_i,
  input  logic             req_bit_i,
  output logic             req_ready_o,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             bit_done_o,
  output logic             rx_bit_o,
  output logic             bus_idle_o
);
  // Times in 0.1 us, fall time of 0.3 us folded in
  localparam int SS_H = (CORE_KHZ * 43 + 5000) / 10000 - 3;
  localparam int SS_L = (CORE_KHZ * 50 + 5000) / 10000 - 1;
  localparam int FS_H = (CORE_KHZ * 9  + 5000) / 10000 - 3;
  localparam int FS_L = (CORE_KHZ * 16 + 5000) / 10000 - 1;

  logic [CNT_W-1:0] hcnt, lcnt;

  scl_cnt_regs #(
    .CNT_W(CNT_W), .SS_H(SS_H), .SS_L(SS_L), .FS_H(FS_H), .FS_L(FS_L)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .lock_i(en_i), .we_i(cfg_we_i),
    .sel_i(cfg_sel_i), .data_i(cfg_data_i), .fast_i(fast_i),
    .hcnt_o(hcnt), .lcnt_o(lcnt)
  );

  scl_phase_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .hcnt_i(hcnt), .lcnt_i(lcnt),
    .req_valid_i(req_valid_i), .req_op_i(req_op_i), .req_bit_i(req_bit_i),
    .req_ready_o(req_ready_o), .sda_i(sda_i), .scl_oe_o(scl_oe_o),
    .sda_oe_o(sda_oe_o), .bit_done_o(bit_done_o), .rx_bit_o(rx_bit_o)
  );

  scl_idle_det #(.CNT_W(CNT_W)) u_idle (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .hcnt_i(hcnt), .idle_o(bus_idle_o)
  );
endmodule

// File: tb/scl_timing_gen_test.sv
module scl_timing_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, fast = 1'b0, cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [15:0] cfg_data = '0;
  logic req_valid = 1'b0, req_bit = 1'b0;
  logic [1:0] req_op = '0;
  logic req_ready, scl_oe, sda_oe, bit_done, rx_bit, bus_idle;
  logic scl_line, sda_line, ext_scl_low = 1'b0;
  int   bit_idx = 0, ack_idx = -1;
  int   cyc = 0, last_chg = 0;
  int   checks = 0, fails = 0;
  bit   mon_on = 1'b1, finished = 1'b0;
  logic [1:0] prev_pair = 2'b00;

  typedef struct {logic [1:0] pair; int len; string req;} seg_t;
  typedef struct {logic b; string req;} rx_t;
  seg_t seg_q[$];
  rx_t  rx_q[$];

  always #5 clk = ~clk;

  assign scl_line = ~scl_oe & ~ext_scl_low;
  assign sda_line = ~sda_oe & ~(bit_idx == ack_idx);

  scl_timing_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .fast_i(fast), .cfg_we_i(cfg_we),
    .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data), .req_valid_i(req_valid),
    .req_op_i(req_op), .req_bit_i(req_bit), .req_ready_o(req_ready),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .bit_done_o(bit_done), .rx_bit_o(rx_bit), .bus_idle_o(bus_idle)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: segment lengths of {scl_oe, sda_oe} and bit-done events
  always @(negedge clk) begin
    logic [1:0] cur;
    cur = {scl_oe, sda_oe};
    if (cur != prev_pair) begin
      if (mon_on) begin
        chk(!(cur[1] != prev_pair[1] && cur[0] != prev_pair[0]), "R12 joint edge",
            int'(cur), int'(prev_pair));
        if (seg_q.size() == 0) begin
          chk(1'b0, "unexpected segment", int'(prev_pair), -1);
        end else begin
          seg_t e;
          e = seg_q.pop_front();
          chk(e.pair == prev_pair, {e.req, " pair"}, int'(prev_pair), int'(e.pair));
          if (e.len != 0) chk(e.len == cyc - last_chg, {e.req, " length"}, cyc - last_chg, e.len);
        end
      end
      last_chg = cyc;
      prev_pair = cur;
    end
    if (bit_done) begin
      if (mon_on) begin
        chk(cur[1] == 1'b1, "R6 done with pull", int'(cur[1]), 1);
        if (rx_q.size() == 0) chk(1'b0, "R6 unexpected bit_done", 1, 0);
        else begin
          rx_t r;
          r = rx_q.pop_front();
          chk(rx_bit == r.b, {r.req, " rx bit"}, int'(rx_bit), int'(r.b));
        end
      end
      bit_idx++;
    end
  end

  task automatic push_seg(input logic [1:0] p, input int len, input string r);
    seg_t s;
    s.pair = p; s.len = len; s.req = r;
    seg_q.push_back(s);
  endtask

  task automatic push_rx(input logic b, input string r);
    rx_t x;
    x.b = b; x.req = r;
    rx_q.push_back(x);
  endtask

  // Driver: called at a negedge, returns at the negedge after acceptance
  task automatic send(input logic [1:0] op, input logic b);
    req_valid = 1'b1; req_op = op; req_bit = b;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wcfg(input logic [1:0] sel, input logic [15:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drain(input string r);
    while (seg_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(rx_q.size() == 0, r, rx_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R10 reset drives", int'({scl_oe, sda_oe}), 0);
    chk(bit_done == 1'b0, "R6 reset done", int'(bit_done), 0);
    chk(req_ready == 1'b0, "R9 ready while disabled", int'(req_ready), 0);

    // Reset count values, standard mode: START then STOP
    en = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready when free", int'(req_ready), 1);
    push_seg(2'b00, 0, "idle");
    push_seg(2'b01, 430, "R1 R3 hold");
    push_seg(2'b11, 500, "R1 R4 low");
    push_seg(2'b01, 428, "R1 R7 stop setup");
    send(2'd1, 1'b0);
    send(2'd2, 1'b0);
    drain("R7 drained");

    // Program small counts while disabled (R2 write path)
    en = 1'b0;
    @(negedge clk);
    wcfg(2'd0, 16'd4); wcfg(2'd1, 16'd6); wcfg(2'd2, 16'd2); wcfg(2'd3, 16'd3);
    en = 1'b1;
    @(negedge clk);

    // Standard: START, bit 1, bit 0, STOP (H=4, L=6)
    push_seg(2'b00, 0, "idle");
    push_seg(2'b01, 7, "R2 R3 hold");
    push_seg(2'b11, 1, "R4 accept");
    push_seg(2'b10, 6, "R4 low");
    push_seg(2'b00, 12, "R5 high");
    push_seg(2'b10, 1, "R4 accept");
    push_seg(2'b11, 6, "R4 low");
    push_seg(2'b01, 12, "R5 high");
    push_seg(2'b11, 7, "R7 low");
    push_seg(2'b01, 5, "R7 stop setup");
    push_rx(1'b1, "R6 released bit");
    push_rx(1'b0, "R6 driven bit");
    send(2'd1, 1'b0);
    send(2'd0, 1'b1);
    send(2'd3, 1'b0);
    send(2'd2, 1'b0);
    drain("R6 rx drained");

    // Write while enabled must be dropped (R2)
    wcfg(2'd2, 16'd9);
    fast = 1'b1;
    ack_idx = 2;
    @(negedge clk);

    // Fast: START, bit 1 acked by slave, repeated START, bit 0, STOP (H=2, L=3)
    push_seg(2'b00, 0, "idle");
    push_seg(2'b01, 5, "R2 R3 hold");
    push_seg(2'b11, 1, "R4 accept");
    push_seg(2'b10, 3, "R4 low");
    push_seg(2'b00, 10, "R5 high");
    push_seg(2'b10, 4, "R8 low");
    push_seg(2'b00, 10, "R8 high");
    push_seg(2'b01, 5, "R8 hold");
    push_seg(2'b11, 4, "R4 low");
    push_seg(2'b01, 10, "R5 high");
    push_seg(2'b11, 4, "R7 low");
    push_seg(2'b01, 3, "R7 stop setup");
    push_rx(1'b0, "R6 ack");
    push_rx(1'b0, "R6 driven bit");
    send(2'd1, 1'b0);
    send(2'd0, 1'b1);
    send(2'd1, 1'b0);
    send(2'd0, 1'b0);
    send(2'd2, 1'b0);
    drain("R8 rx drained");

    // Bit and STOP while free: no effect (R9)
    fast = 1'b0;
    send(2'd0, 1'b0);
    repeat (4) @(negedge clk);
    chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R9 bit while free", int'({scl_oe, sda_oe}), 0);
    send(2'd2, 1'b0);
    repeat (4) @(negedge clk);
    chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R9 stop while free", int'({scl_oe, sda_oe}), 0);

    // Bus-free detector, H=4 (R11)
    chk(bus_idle == 1'b1, "R11 idle after long high", int'(bus_idle), 1);
    ext_scl_low = 1'b1;
    @(negedge clk);
    chk(bus_idle == 1'b0, "R11 drop on low", int'(bus_idle), 0);
    ext_scl_low = 1'b0;
    repeat (4) @(negedge clk);
    chk(bus_idle == 1'b0, "R11 after H edges", int'(bus_idle), 0);
    @(negedge clk);
    chk(bus_idle == 1'b1, "R11 after H+1 edges", int'(bus_idle), 1);

    // Disable during a START hold (R10)
    mon_on = 1'b0;
    send(2'd1, 1'b0);
    chk(sda_oe == 1'b1, "R3 sda at accept", int'(sda_oe), 1);
    en = 1'b0;
    @(negedge clk);
    chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R10 release", int'({scl_oe, sda_oe}), 0);
    chk(req_ready == 1'b0, "R10 not ready", int'(req_ready), 0);
    en = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && scl_oe == 1'b0 && sda_oe == 1'b0, "R10 back to free",
        int'({req_ready, scl_oe, sda_oe}), 4);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule